// File: doc/BRIEF.md
# Display register command-stream executor

This block walks a queue of register-write instructions held in memory and replays them onto an internal, write-only register bus. Software first turns the engine on through a control word, then loads a start pointer, and finally loads an end pointer. Loading the end pointer launches the run. The engine then fetches 64-bit instruction pairs one at a time from the start pointer upward, decodes each pair, and issues register writes until its fetch address equals the end pointer.

Two instruction kinds exist. A single write carries one data word and an opcode word with its own byte-enable field. A burst write carries a count and a register offset, followed by that many data words, all written to the same offset. A burst with an odd count ends with one padding word, so the next instruction starts on an 8-byte boundary. Software fills the space up to a 64-byte boundary with all-zero pairs, and the engine steps over them. Any other nonzero opcode halts the run and raises a sticky fault flag.

Top module: `rcx_engine`

## Requirements
- R1: After reset, sts_enable, sts_busy and sts_error are 0, and neither reg_wr nor mem_req is asserted.
- R2: A pair whose upper word has bits 31:24 equal to 0x01 produces one register write. Its reg_addr is upper-word bits 19:0, its reg_be is upper-word bits 23:20 passed through unchanged (including 0), and its reg_wdata is the lower word.
- R3: A pair whose upper word has bits 31:24 equal to 0x09 starts a burst of N writes, where N is the lower word. The writes go to offset upper[19:0], take the data words that follow in memory order (lower word of each pair first), and always use reg_be = 4'hF.
- R4: When N is odd, the upper word of the final data pair is padding. It is never written, and the instruction in the next pair is decoded normally.
- R5: A pair that is entirely zero produces no register write, and the fetch continues with the next pair.
- R6: A control write (cfg_sel 0) sets enable from bit 0, and its bit 1 clears the fault flag. Writing the start pointer (cfg_sel 1) or the end pointer (cfg_sel 2) takes effect only while enabled and idle. Bits 2:0 of both pointers are forced to 0. An accepted end-pointer write that differs from the start pointer starts a run.
- R7: While sts_busy is 1, all configuration writes are ignored, so sts_enable cannot change.
- R8: sts_busy reads 1 from the cycle after the launching end-pointer write. It falls in the cycle after the last action at the end pointer (a write accepted, or a zero pair consumed).
- R9: A pair that is not all-zero and whose opcode is neither 0x01 nor 0x09 produces no write and stops fetching. It sets sts_error, which stays set until a control write with bit 1 set, and sts_busy drops the next cycle.
- R10: Fetches are single-cycle mem_req pulses at 8-byte aligned byte addresses, rising by 8 from the start pointer, with no fetch at the end pointer. In mem_rdata, bits 31:0 hold the word at the lower address.
- R11: A register write with reg_ready low keeps reg_wr, reg_addr, reg_be and reg_wdata unchanged until reg_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 control, 1 start pointer, 2 end pointer |
| cfg_wdata | input | MEM_AW | Configuration write data |
| sts_enable | output | 1 | Engine enabled |
| sts_busy | output | 1 | Run in progress |
| sts_error | output | 1 | Sticky fault flag for an unknown opcode |
| mem_req | output | 1 | Fetch request pulse |
| mem_addr | output | MEM_AW | Fetch byte address |
| mem_rvalid | input | 1 | Fetch data valid |
| mem_rdata | input | 64 | Fetched pair, lower address in bits 31:0 |
| reg_wr | output | 1 | Register write request |
| reg_addr | output | 20 | Register offset |
| reg_be | output | 4 | Byte enables |
| reg_wdata | output | 32 | Register write data |
| reg_ready | input | 1 | Register bus accepts the write |

## Verification
The end-pointer write launches the run at the clock edge where it is taken, so the bench checks sts_busy at the falling edge right after it. The first fetch pulse appears in that same cycle. With the bench memory answering one cycle after a request, a register write is offered two cycles after its fetch pulse. sts_busy must read 0 at the falling edge one cycle after the final accepted write. The bench records every accepted write and every fetch address at falling edges, when all outputs are settled, and compares those records with lists built from the requirements once the engine goes idle. The fault and ignore cases are read back through the status outputs and the logs before the next stimulus.

// File: rtl/rcx_pkg.sv
package rcx_pkg;
   localparam int WORD_W    = 32;
   localparam int PAIR_W    = 64;
   localparam int REG_OFF_W = 20;
   localparam int BE_W      = 4;
   localparam logic [7:0] OP_SINGLE = 8'h01;
   localparam logic [7:0] OP_BURST  = 8'h09;

   typedef enum logic [1:0] {
      SEL_CTRL  = 2'd0,
      SEL_START = 2'd1,
      SEL_END   = 2'd2
   } cfg_sel_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REQ,
      ST_WAIT,
      ST_SINGLE,
      ST_BURST_LO,
      ST_BURST_HI
   } core_st_e;
endpackage

// File: rtl/rcx_cfg.sv
module rcx_cfg
   import rcx_pkg::*;
#(
   parameter int MEM_AW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_sel,
   input  logic [MEM_AW-1:0] cfg_wdata,
   input  logic              busy,
   input  logic              fault_set,
   output logic              enable,
   output logic              fault,
   output logic [MEM_AW-1:0] start_ptr,
   output logic [MEM_AW-1:0] end_ptr,
   output logic              launch
);
   localparam logic [MEM_AW-1:0] ALIGN_MASK = ~MEM_AW'(7);

   logic [MEM_AW-1:0] new_ptr;
   logic              cfg_ok;

   assign new_ptr = cfg_wdata & ALIGN_MASK;
   assign cfg_ok  = cfg_wr && !busy;
   assign launch  = cfg_ok && enable && (cfg_sel == SEL_END) && (new_ptr != start_ptr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enable    <= 1'b0;
         fault     <= 1'b0;
         start_ptr <= '0;
         end_ptr   <= '0;
      end else begin
         if (cfg_ok) begin
            case (cfg_sel)
               SEL_CTRL: begin
                  enable <= cfg_wdata[0];
                  if (cfg_wdata[1]) fault <= 1'b0;
               end
               SEL_START: if (enable) start_ptr <= new_ptr;
               SEL_END:   if (enable) end_ptr   <= new_ptr;
               default: ;
            endcase
         end
         if (fault_set) fault <= 1'b1;
      end
   end
endmodule

// File: rtl/rcx_decode.sv
module rcx_decode
   import rcx_pkg::*;
(
   input  logic [PAIR_W-1:0]    pair,
   output logic                 is_nop,
   output logic                 is_single,
   output logic                 is_burst,
   output logic                 is_bad,
   output logic [REG_OFF_W-1:0] offset,
   output logic [BE_W-1:0]      be
);
   logic [7:0] opcode;

   assign opcode    = pair[PAIR_W-1 -: 8];
   assign is_nop    = (pair == '0);
   assign is_single = (opcode == OP_SINGLE);
   assign is_burst  = (opcode == OP_BURST);
   assign is_bad    = !is_nop && !is_single && !is_burst;
   assign offset    = pair[WORD_W +: REG_OFF_W];
   assign be        = pair[WORD_W+REG_OFF_W +: BE_W];
endmodule

// File: rtl/rcx_core.sv
module rcx_core
   import rcx_pkg::*;
#(
   parameter int MEM_AW = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 launch,
   input  logic [MEM_AW-1:0]    start_ptr,
   input  logic [MEM_AW-1:0]    end_ptr,
   output logic                 busy,
   output logic                 fault_set,
   output logic                 mem_req,
   output logic [MEM_AW-1:0]    mem_addr,
   input  logic                 mem_rvalid,
   input  logic [PAIR_W-1:0]    mem_rdata,
   output logic                 reg_wr,
   output logic [REG_OFF_W-1:0] reg_addr,
   output logic [BE_W-1:0]      reg_be,
   output logic [WORD_W-1:0]    reg_wdata,
   input  logic                 reg_ready
);
   localparam logic [MEM_AW-1:0] PAIR_BYTES = MEM_AW'(8);

   core_st_e             st;
   logic [MEM_AW-1:0]    addr;
   logic [WORD_W-1:0]    lo_w, hi_w, remain;
   logic [REG_OFF_W-1:0] off_q;
   logic [BE_W-1:0]      be_q;

   logic                 d_nop, d_single, d_burst, d_bad;
   logic [REG_OFF_W-1:0] d_off;
   logic [BE_W-1:0]      d_be;
   logic [MEM_AW-1:0]    nxt;
   logic                 accept;
   core_st_e             after_pair;

   rcx_decode u_dec (
      .pair      (mem_rdata),
      .is_nop    (d_nop),
      .is_single (d_single),
      .is_burst  (d_burst),
      .is_bad    (d_bad),
      .offset    (d_off),
      .be        (d_be)
   );

   assign nxt        = addr + PAIR_BYTES;
   assign after_pair = (nxt == end_ptr) ? ST_IDLE : ST_REQ;
   assign accept     = reg_wr && reg_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         addr   <= '0;
         lo_w   <= '0;
         hi_w   <= '0;
         remain <= '0;
         off_q  <= '0;
         be_q   <= '0;
      end else begin
         case (st)
            ST_IDLE: if (launch) begin
               addr   <= start_ptr;
               remain <= '0;
               st     <= ST_REQ;
            end
            ST_REQ: st <= ST_WAIT;
            ST_WAIT: if (mem_rvalid) begin
               lo_w <= mem_rdata[WORD_W-1:0];
               hi_w <= mem_rdata[PAIR_W-1:WORD_W];
               if (remain != '0) begin
                  st <= ST_BURST_LO;
               end else if (d_nop) begin
                  addr <= nxt;
                  st   <= after_pair;
               end else if (d_single) begin
                  off_q <= d_off;
                  be_q  <= d_be;
                  st    <= ST_SINGLE;
               end else if (d_burst) begin
                  off_q  <= d_off;
                  be_q   <= '1;
                  remain <= mem_rdata[WORD_W-1:0];
                  addr   <= nxt;
                  st     <= after_pair;
               end else begin
                  st <= ST_IDLE;
               end
            end
            ST_SINGLE: if (accept) begin
               addr <= nxt;
               st   <= after_pair;
            end
            ST_BURST_LO: if (accept) begin
               remain <= remain - WORD_W'(1);
               if (remain == WORD_W'(1)) begin
                  addr <= nxt;
                  st   <= after_pair;
               end else begin
                  st <= ST_BURST_HI;
               end
            end
            ST_BURST_HI: if (accept) begin
               remain <= remain - WORD_W'(1);
               addr   <= nxt;
               st     <= after_pair;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (st != ST_IDLE);
   assign fault_set = (st == ST_WAIT) && mem_rvalid && (remain == '0) && d_bad;
   assign mem_req   = (st == ST_REQ);
   assign mem_addr  = addr;
   assign reg_wr    = (st == ST_SINGLE) || (st == ST_BURST_LO) || (st == ST_BURST_HI);
   assign reg_addr  = off_q;
   assign reg_be    = be_q;
   assign reg_wdata = (st == ST_BURST_HI) ? hi_w : lo_w;
endmodule

// File: rtl/rcx_engine.sv
module rcx_engine
   import rcx_pkg::*;
#(
   parameter int MEM_AW = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_wr,
   input  logic [1:0]           cfg_sel,
   input  logic [MEM_AW-1:0]    cfg_wdata,
   output logic                 sts_enable,
   output logic                 sts_busy,
   output logic                 sts_error,
   output logic                 mem_req,
   output logic [MEM_AW-1:0]    mem_addr,
   input  logic                 mem_rvalid,
   input  logic [PAIR_W-1:0]    mem_rdata,
   output logic                 reg_wr,
   output logic [REG_OFF_W-1:0] reg_addr,
   output logic [BE_W-1:0]      reg_be,
   output logic [WORD_W-1:0]    reg_wdata,
   input  logic                 reg_ready
);
   if (MEM_AW < 7 || MEM_AW > 32) begin : g_bad_aw
      $error("rcx_engine: MEM_AW must lie in 7..32");
   end

   logic              launch, fault_set;
   logic [MEM_AW-1:0] start_ptr, end_ptr;

   rcx_cfg #(.MEM_AW(MEM_AW)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .busy      (sts_busy),
      .fault_set (fault_set),
      .enable    (sts_enable),
      .fault     (sts_error),
      .start_ptr (start_ptr),
      .end_ptr   (end_ptr),
      .launch    (launch)
   );

   rcx_core #(.MEM_AW(MEM_AW)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .launch     (launch),
      .start_ptr  (start_ptr),
      .end_ptr    (end_ptr),
      .busy       (sts_busy),
      .fault_set  (fault_set),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_rvalid (mem_rvalid),
      .mem_rdata  (mem_rdata),
      .reg_wr     (reg_wr),
      .reg_addr   (reg_addr),
      .reg_be     (reg_be),
      .reg_wdata  (reg_wdata),
      .reg_ready  (reg_ready)
   );
endmodule

// File: rtl/rcx_engine_chk.sv
module rcx_engine_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        sts_enable,
   input logic        sts_busy,
   input logic        sts_error,
   input logic        mem_req,
   input logic [2:0]  mem_addr_lo,
   input logic        reg_wr,
   input logic        reg_ready,
   input logic [19:0] reg_addr,
   input logic [3:0]  reg_be,
   input logic [31:0] reg_wdata
);
   p_reset_r1: assert property (@(posedge clk)
      !rst_n |=> (!sts_busy && !sts_error && !sts_enable && !reg_wr && !mem_req));

   p_busy_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sts_busy |-> sts_enable);

   p_en_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sts_busy |=> $stable(sts_enable));

   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !sts_busy |-> (!mem_req && !reg_wr));

   p_err_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_error) |-> !sts_busy);

   p_align_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr_lo == 3'd0));

   p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_ready) |=>
         (reg_wr && $stable(reg_addr) && $stable(reg_be) && $stable(reg_wdata)));
endmodule

bind rcx_engine rcx_engine_chk chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .sts_enable  (sts_enable),
   .sts_busy    (sts_busy),
   .sts_error   (sts_error),
   .mem_req     (mem_req),
   .mem_addr_lo (mem_addr[2:0]),
   .reg_wr      (reg_wr),
   .reg_ready   (reg_ready),
   .reg_addr    (reg_addr),
   .reg_be      (reg_be),
   .reg_wdata   (reg_wdata)
);

// File: tb/rcx_engine_tb_top.sv
module rcx_engine_tb_top;
   localparam int CLK_P  = 10;
   localparam int MEM_AW = 16;
   localparam logic [1:0] C_CTRL = 2'd0, C_START = 2'd1, C_END = 2'd2;

   // single-write vectors: {offset[19:0], be[3:0], data[31:0]}
   localparam int NVEC = 6;
   localparam logic [55:0] DIR_VEC [NVEC] = '{
      {20'h00010, 4'hF, 32'h1234_5678},
      {20'hFFFFF, 4'h1, 32'hDEAD_BEEF},
      {20'h00000, 4'h0, 32'h0000_0001},
      {20'h5A5A5, 4'hA, 32'hFFFF_FFFF},
      {20'h80001, 4'h6, 32'h0F0F_0F0F},
      {20'h00400, 4'h8, 32'h8000_0000}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_wr = 1'b0;
   logic [1:0]        cfg_sel = 2'd0;
   logic [MEM_AW-1:0] cfg_wdata = '0;
   logic              sts_enable, sts_busy, sts_error;
   logic              mem_req;
   logic [MEM_AW-1:0] mem_addr;
   logic              mem_rvalid = 1'b0;
   logic [63:0]       mem_rdata = '0;
   logic              reg_wr;
   logic [19:0]       reg_addr;
   logic [3:0]        reg_be;
   logic [31:0]       reg_wdata;
   logic              reg_ready;
   logic              stall_en = 1'b0;
   logic              rdy_t = 1'b0;

   logic [63:0]       mem [64];
   logic [19:0]       log_addr [32];
   logic [3:0]        log_be   [32];
   logic [31:0]       log_data [32];
   logic [MEM_AW-1:0] req_log  [32];
   int                n_log = 0, n_req = 0;
   int                n_tests = 0, n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   rcx_engine #(.MEM_AW(MEM_AW)) dut_i (.*);

   always_ff @(posedge clk) begin
      mem_rvalid <= mem_req;
      if (mem_req) mem_rdata <= mem[mem_addr[8:3]];
      rdy_t <= ~rdy_t;
   end
   assign reg_ready = stall_en ? rdy_t : 1'b1;

   always @(negedge clk) begin
      if (reg_wr && reg_ready && n_log < 32) begin
         log_addr[n_log] = reg_addr;
         log_be[n_log]   = reg_be;
         log_data[n_log] = reg_wdata;
         n_log++;
      end
      if (mem_req && n_req < 32) begin
         req_log[n_req] = mem_addr;
         n_req++;
      end
   end

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic cfg_write(input logic [1:0] sel, input logic [MEM_AW-1:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 2000; i++) begin
         if (!sts_busy) break;
         @(negedge clk);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 64; i++) mem[i] = '0;
   endtask

   task automatic clear_log();
      @(negedge clk);
      n_log = 0; n_req = 0;
   endtask

   function automatic logic [31:0] op_word(input logic [7:0] op, input logic [3:0] be,
                                           input logic [19:0] off);
      return {op, be, off};
   endfunction

   task automatic chk_write(input string tag, input int k, input logic [19:0] a,
                            input logic [3:0] b, input logic [31:0] d);
      chk({tag, " addr"}, 64'(log_addr[k]), 64'(a));
      chk({tag, " be"},   64'(log_be[k]),   64'(b));
      chk({tag, " data"}, 64'(log_data[k]), 64'(d));
   endtask

   initial begin
      #(CLK_P * 150000);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      clear_mem();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 enable", 64'(sts_enable), 64'd0);
      chk("R1 busy",   64'(sts_busy),   64'd0);
      chk("R1 error",  64'(sts_error),  64'd0);
      chk("R1 reg_wr", 64'(reg_wr),     64'd0);
      chk("R1 mem_req", 64'(mem_req),   64'd0);

      cfg_write(C_CTRL, 16'h0001);
      chk("R6 enable set", 64'(sts_enable), 64'd1);

      // R2: table of single writes, one per run
      for (int v = 0; v < NVEC; v++) begin
         clear_mem();
         mem[8] = {op_word(8'h01, DIR_VEC[v][35:32], DIR_VEC[v][55:36]), DIR_VEC[v][31:0]};
         cfg_write(C_START, 16'h0040);
         clear_log();
         cfg_write(C_END, 16'h0048);
         wait_idle();
         chk("R2 count", 64'(n_log), 64'd1);
         chk_write("R2", 0, DIR_VEC[v][55:36], DIR_VEC[v][35:32], DIR_VEC[v][31:0]);
      end

      // R8: busy timing around a single write
      clear_log();
      cfg_write(C_END, 16'h0048);
      chk("R8 busy after launch", 64'(sts_busy), 64'd1);
      for (int i = 0; i < 20; i++) begin
         if (reg_wr) break;
         @(negedge clk);
      end
      chk("R8 busy during write", 64'(sts_busy), 64'd1);
      @(negedge clk);
      chk("R8 busy clear", 64'(sts_busy), 64'd0);

      // R3 R4 R5 R10 R11 R7: odd burst, padding, single, zero fill, stalls
      clear_mem();
      mem[8]  = {op_word(8'h09, 4'h0, 20'h00123), 32'd3};
      mem[9]  = {32'hA2A2_A2A2, 32'hA1A1_A1A1};
      mem[10] = {32'h0000_0000, 32'hA3A3_A3A3};
      mem[11] = {op_word(8'h01, 4'h5, 20'h00456), 32'hD00D_F00D};
      stall_en = 1'b1;
      cfg_write(C_START, 16'h0040);
      clear_log();
      cfg_write(C_END, 16'h0080);
      cfg_write(C_CTRL, 16'h0000);
      cfg_write(C_END, 16'h0048);
      wait_idle();
      stall_en = 1'b0;
      chk("R7 enable kept", 64'(sts_enable), 64'd1);
      chk("R5 write count", 64'(n_log), 64'd4);
      chk_write("R3 v1", 0, 20'h00123, 4'hF, 32'hA1A1_A1A1);
      chk_write("R3 v2", 1, 20'h00123, 4'hF, 32'hA2A2_A2A2);
      chk_write("R4 v3", 2, 20'h00123, 4'hF, 32'hA3A3_A3A3);
      chk_write("R4 next", 3, 20'h00456, 4'h5, 32'hD00D_F00D);
      chk("R10 fetch count", 64'(n_req), 64'd8);
      for (int i = 0; i < 8; i++)
         chk("R10 fetch addr", 64'(req_log[i]), 64'(16'h0040 + 16'(8 * i)));

      // R3: even burst, no padding
      mem[16] = {op_word(8'h09, 4'h0, 20'h00200), 32'd2};
      mem[17] = {32'hB2B2_B2B2, 32'hB1B1_B1B1};
      mem[18] = {op_word(8'h01, 4'hC, 20'h00300), 32'hC0C0_C0C0};
      cfg_write(C_START, 16'h0080);
      clear_log();
      cfg_write(C_END, 16'h0098);
      wait_idle();
      chk("R3 even count", 64'(n_log), 64'd3);
      chk_write("R3 e1", 0, 20'h00200, 4'hF, 32'hB1B1_B1B1);
      chk_write("R3 e2", 1, 20'h00200, 4'hF, 32'hB2B2_B2B2);
      chk_write("R3 e3", 2, 20'h00300, 4'hC, 32'hC0C0_C0C0);

      // R9: unknown opcode halts the run
      mem[32] = {op_word(8'h01, 4'hF, 20'h00011), 32'h0000_00AA};
      mem[33] = {32'h0500_0020, 32'd5};
      mem[34] = {op_word(8'h01, 4'hF, 20'h00022), 32'h0000_00BB};
      cfg_write(C_START, 16'h0100);
      clear_log();
      cfg_write(C_END, 16'h0118);
      wait_idle();
      chk("R9 writes", 64'(n_log), 64'd1);
      chk("R9 fetches", 64'(n_req), 64'd2);
      chk("R9 error set", 64'(sts_error), 64'd1);
      chk("R9 busy clear", 64'(sts_busy), 64'd0);
      cfg_write(C_CTRL, 16'h0001);
      chk("R9 error sticky", 64'(sts_error), 64'd1);
      cfg_write(C_CTRL, 16'h0003);
      chk("R9 error cleared", 64'(sts_error), 64'd0);
      chk("R9 enable kept", 64'(sts_enable), 64'd1);

      // R6: pointer writes ignored while disabled
      cfg_write(C_CTRL, 16'h0000);
      clear_log();
      cfg_write(C_START, 16'h0040);
      cfg_write(C_END, 16'h0108);
      chk("R6 no launch when off", 64'(sts_busy), 64'd0);
      repeat (5) @(negedge clk);
      chk("R6 no writes when off", 64'(n_log), 64'd0);
      cfg_write(C_CTRL, 16'h0001);
      clear_log();
      cfg_write(C_END, 16'h0108);
      wait_idle();
      chk("R6 old start kept", 64'(n_log), 64'd1);
      chk_write("R6 run", 0, 20'h00011, 4'hF, 32'h0000_00AA);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule